// File: doc/BRIEF.md
# At-Speed Scan Capture Clock Controller

This block produces the clock for one clock domain during scan test. It selects between the on-chip PLL clock and the slow clock from the tester. In functional operation the PLL clock goes straight to the domain with no gating. While a scan load or unload is in progress, the tester clock drives the domain. When the shift ends, the block delivers one of two kinds of capture. A stuck-at capture is a single pulse of the tester clock. An at-speed capture is a burst of one or two PLL-rate pulses: first the launch, then the capture, with no gap between them.

Every clock domain gets its own instance. The end of shift reaches the fast domain through a synchronizer, so the tester can drop scan enable with no timing relation to the PLL clock. All gate enables are held in flops clocked on the falling edge of the clock they gate. An enable can therefore change only while its clock is low, and no output pulse is ever cut short. After a capture the output stays quiet until a new shift phase has started. `test_mode`, `at_speed` and `burst_two` are quasi-static: they are set while scan enable is low and the capture has finished.

Top module: `scan_clk_ctrl`

## Requirements
- R1: With test_mode low, clk_out follows clk_pll on every edge, whatever the other inputs do.
- R2: After reset, with test_mode high and scan_enable low, clk_out has no rising edge until scan_enable has been high.
- R3: With test_mode and scan_enable both high, clk_out carries the tester clock. Its gate opens at the first tester falling edge after scan_enable rises. This holds for both values of at_speed.
- R4: With at_speed low (stuck-at capture), exactly one tester-clock pulse reaches clk_out after scan_enable falls, with the full tester high phase.
- R5: With at_speed high (at-speed capture), the capture pulses come from clk_pll. The burst is started only by the closing of the tester gate, after that event has passed a synchronizer of SYNC_STAGES flops (default 2) clocked by the PLL clock. No tester pulse appears during capture.
- R6: With burst_two high (value 1), the at-speed burst is exactly two PLL pulses, one PLL period apart, each with the full PLL high phase.
- R7: With burst_two low (value 0), the at-speed burst is exactly one PLL pulse.
- R8: After a capture, further tester or PLL edges are blocked while scan_enable stays low. The next capture needs a new shift phase.
- R9: Each gate enable changes only on a falling edge of the clock it gates, so no pulse on clk_out is shorter than a full source high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pll | input | 1 | Functional clock from the PLL |
| clk_tck | input | 1 | Slow shift clock from the tester |
| rst_n | input | 1 | Active-low reset, synchronous to each clock |
| test_mode | input | 1 | 1 selects scan test operation, 0 selects functional |
| scan_enable | input | 1 | 1 = shift phase, its fall starts a capture |
| at_speed | input | 1 | 1 = PLL-rate capture burst, 0 = single tester pulse |
| burst_two | input | 1 | 1 = launch and capture pulses, 0 = one fast pulse |
| clk_out | output | 1 | Gated clock to the domain |

## Verification
On every cycle the assertions check the gate enables. Shift always opens the tester gate. A stuck-at capture enable lasts a single tester period. A fast burst opens only one cycle after the synchronized gate fell, never lasts longer than two PLL periods, and lasts one period when a single pulse is selected. Functional mode keeps the fast gate shut. Some properties hold only at the port, across both clock domains and the output combiner, and only the bench scenarios show them. These are the pulse counts in each phase, the spacing and high time of the burst pulses, the quiet interval after each capture and the plain pass-through in functional mode.

// File: rtl/scan_clk_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the scan capture clock controller.
// Assumes: mode inputs are quasi-static relative to the clocks that decode them.
package scan_clk_pkg;

    typedef enum logic [1:0] {
        MODE_FUNC   = 2'd0,
        MODE_SHIFT  = 2'd1,
        MODE_SA_CAP = 2'd2,
        MODE_AS_CAP = 2'd3
    } clk_mode_e;

    // Decode the operating mode from the test control pins.
    function automatic clk_mode_e decode_mode(input logic tm, input logic se, input logic fast);
        if (!tm)
            return MODE_FUNC;
        else if (se)
            return MODE_SHIFT;
        else if (fast)
            return MODE_AS_CAP;
        else
            return MODE_SA_CAP;
    endfunction

endpackage

// File: rtl/scan_clk_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer that brings a level into a destination clock domain.
// Sampled on the falling edge, so its output feeds falling-edge gate logic directly.
// Assumes: STAGES >= 2; the input level is held for several destination cycles.
module scan_clk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(negedge clk) begin
        if (!rst_n)
            chain <= '0;
        else
            chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/scan_clk_tck_gate.sv
`timescale 1ns/1ps
// Tester-clock gate: passes the shift clock while scan enable is high and lets
// a single stuck-at capture pulse through after shift ends.
// Assumes: scan_enable changes while clk_tck is high or far from its falling edge.
module scan_clk_tck_gate
    import scan_clk_pkg::*;
(
    input  logic clk_tck,
    input  logic rst_n,
    input  logic test_mode,
    input  logic scan_enable,
    input  logic at_speed,
    output logic tck_en
);
    logic      used_q;
    clk_mode_e mode;

    assign mode = decode_mode(test_mode, scan_enable, at_speed);

    // Update the gate enable while the tester clock is low.
    always_ff @(negedge clk_tck) begin
        if (!rst_n) begin
            tck_en <= 1'b0;
            used_q <= 1'b1;
        end else begin
            unique case (mode)
                MODE_SHIFT: begin
                    tck_en <= 1'b1;
                    used_q <= 1'b0;
                end
                MODE_SA_CAP: begin
                    tck_en <= !used_q;
                    used_q <= 1'b1;
                end
                default: begin
                    tck_en <= 1'b0;
                    used_q <= 1'b1;
                end
            endcase
        end
    end

    // R3
    shift_open_chk: assert property (@(negedge clk_tck) disable iff (!rst_n)
        (test_mode && scan_enable) |=> tck_en);

    // R4
    sa_single_chk: assert property (@(negedge clk_tck) disable iff (!rst_n)
        (tck_en && used_q && !scan_enable) |=> !tck_en);
endmodule

// File: rtl/scan_clk_burst.sv
`timescale 1ns/1ps
// Fast-burst gate: when the tester gate closes, as seen through a synchronizer,
// it opens the PLL gate for one or two consecutive PLL periods.
// Assumes: at_speed, test_mode and burst_two are stable across a capture.
module scan_clk_burst #(
    parameter int SYNC_STAGES = 2,
    parameter int MAX_BURST   = 2
) (
    input  logic clk_pll,
    input  logic rst_n,
    input  logic test_mode,
    input  logic at_speed,
    input  logic burst_two,
    input  logic tck_gate,
    output logic pll_en
);
    localparam int CNT_W = (MAX_BURST > 2) ? $clog2(MAX_BURST) : 1;

    logic             gate_s;
    logic             gate_d;
    logic [CNT_W-1:0] left_q;
    logic             fire;

    scan_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_pll),
        .rst_n (rst_n),
        .d     (tck_gate),
        .q     (gate_s)
    );

    // A burst starts when the synchronized tester gate falls in at-speed mode.
    assign fire = gate_d && !gate_s && test_mode && at_speed;

    // Hold the previous synchronized gate level for edge detection.
    always_ff @(negedge clk_pll) begin
        if (!rst_n)
            gate_d <= 1'b0;
        else
            gate_d <= gate_s;
    end

    // Count the remaining burst periods and drive the PLL gate enable.
    always_ff @(negedge clk_pll) begin
        if (!rst_n || !(test_mode && at_speed)) begin
            pll_en <= 1'b0;
            left_q <= '0;
        end else if (fire) begin
            pll_en <= 1'b1;
            left_q <= burst_two ? CNT_W'(1) : '0;
        end else if (pll_en && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end else begin
            pll_en <= 1'b0;
        end
    end

    // R5
    burst_start_chk: assert property (@(negedge clk_pll) disable iff (!rst_n)
        $rose(pll_en) |-> ($past(gate_d) && !$past(gate_s)));

    // R6
    burst_len_chk: assert property (@(negedge clk_pll) disable iff (!rst_n)
        (pll_en && $past(pll_en)) |=> !pll_en);

    // R7
    burst_one_chk: assert property (@(negedge clk_pll) disable iff (!rst_n)
        ($rose(pll_en) && !burst_two) |=> !pll_en);

    // R1
    func_quiet_chk: assert property (@(negedge clk_pll) disable iff (!rst_n)
        !test_mode |=> !pll_en);
endmodule

// File: rtl/scan_clk_ctrl.sv
`timescale 1ns/1ps
// Per-domain scan clock controller: functional pass-through, tester shift clock,
// single stuck-at capture pulse or a PLL-rate launch/capture burst.
// Assumes: mode pins are changed only with scan_enable low and capture complete.
module scan_clk_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int MAX_BURST   = 2
) (
    input  logic clk_pll,
    input  logic clk_tck,
    input  logic rst_n,
    input  logic test_mode,
    input  logic scan_enable,
    input  logic at_speed,
    input  logic burst_two,
    output logic clk_out
);
    logic tck_en;
    logic pll_en;

    scan_clk_tck_gate u_tck_gate (
        .clk_tck     (clk_tck),
        .rst_n       (rst_n),
        .test_mode   (test_mode),
        .scan_enable (scan_enable),
        .at_speed    (at_speed),
        .tck_en      (tck_en)
    );

    scan_clk_burst #(
        .SYNC_STAGES (SYNC_STAGES),
        .MAX_BURST   (MAX_BURST)
    ) u_burst (
        .clk_pll   (clk_pll),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .at_speed  (at_speed),
        .burst_two (burst_two),
        .tck_gate  (tck_en),
        .pll_en    (pll_en)
    );

    // Combine the two gated sources; functional mode bypasses all gating.
    always_comb begin
        if (test_mode)
            clk_out = (clk_tck & tck_en) | (clk_pll & pll_en);
        else
            clk_out = clk_pll;
    end
endmodule

// File: tb/scan_clk_ctrl_tb.sv
`timescale 1ns/1ps
module scan_clk_ctrl_tb;
    typedef struct {
        string tag;
        real   exp;
        real   act;
    } sb_item_t;

    logic clk_pll = 1'b0;
    logic clk_tck = 1'b0;
    logic rst_n = 1'b0;
    logic test_mode = 1'b1;
    logic scan_enable = 1'b0;
    logic at_speed = 1'b0;
    logic burst_two = 1'b1;
    logic clk_out;

    int  checks = 0;
    int  fails = 0;
    int  edges = 0;
    real last_rise = 0.0;
    real prev_rise = 0.0;
    real last_fall = 0.0;
    sb_item_t sb_q[$];
    event     sb_ev;

    always #4 clk_pll = ~clk_pll;
    initial begin
        #1;
        forever #40 clk_tck = ~clk_tck;
    end

    scan_clk_ctrl u_dut (
        .clk_pll     (clk_pll),
        .clk_tck     (clk_tck),
        .rst_n       (rst_n),
        .test_mode   (test_mode),
        .scan_enable (scan_enable),
        .at_speed    (at_speed),
        .burst_two   (burst_two),
        .clk_out     (clk_out)
    );

    always @(posedge clk_out) begin
        edges++;
        prev_rise = last_rise;
        last_rise = $realtime;
    end
    always @(negedge clk_out) last_fall = $realtime;

    function automatic void drain();
        while (sb_q.size() > 0) begin
            sb_item_t it = sb_q.pop_front();
            checks++;
            if (it.act != it.exp) begin
                fails++;
                $display("FAIL %s actual=%0.3f expected=%0.3f", it.tag, it.act, it.exp);
            end
        end
    endfunction

    // Monitor: compares queued expectations as they are produced.
    initial forever begin
        @(sb_ev);
        drain();
    end

    task automatic push(input string tag, input real exp, input real act);
        sb_item_t it;
        it.tag = tag;
        it.exp = exp;
        it.act = act;
        sb_q.push_back(it);
        -> sb_ev;
    endtask

    // Count clk_out rising edges over a window and queue the expectation.
    task automatic window(input string tag, input int len_ns, input int exp);
        int base = edges;
        #(len_ns);
        push(tag, exp, edges - base);
    endtask

    // Change scan_enable while the tester clock is high; return at posedge+30.
    task automatic set_se(input logic v);
        @(posedge clk_tck);
        #20 scan_enable = v;
        #10;
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk_tck);
        #20 rst_n = 1'b1;

        // R2: no edges after reset before a shift phase
        window("R2 reset quiet", 800, 0);

        // R1: functional pass-through
        test_mode = 1'b0;
        #200;
        @(negedge clk_pll);
        window("R1 functional edges", 160, 20);
        test_mode = 1'b1;
        #200;

        // R3: shift in stuck-at selection
        set_se(1'b1);
        window("R3 shift edges (stuck-at)", 640, 8);

        // R4: single tester capture pulse with full high phase
        set_se(1'b0);
        window("R4 stuck-at capture edges", 800, 1);
        push("R4/R9 stuck-at pulse width", 40.0, last_fall - last_rise);

        // R8: no further pulse while scan_enable stays low
        window("R8 stuck-at post-capture quiet", 800, 0);

        // R3: shift in at-speed selection
        at_speed = 1'b1;
        burst_two = 1'b1;
        set_se(1'b1);
        window("R3 shift edges (at-speed)", 640, 8);

        // R5/R6: two PLL-rate pulses after shift ends
        set_se(1'b0);
        window("R5/R6 at-speed burst edges", 800, 2);
        push("R6 launch-to-capture spacing", 8.0, last_rise - prev_rise);
        push("R6/R9 capture pulse width", 4.0, last_fall - last_rise);

        // R8: burst is not repeated without a new shift
        window("R8 at-speed post-capture quiet", 800, 0);

        // R7: single fast pulse
        burst_two = 1'b0;
        set_se(1'b1);
        #320;
        set_se(1'b0);
        window("R7 single fast pulse edges", 800, 1);
        push("R7/R9 single pulse width", 4.0, last_fall - last_rise);

        // R1: back to functional after test
        test_mode = 1'b0;
        at_speed = 1'b0;
        #200;
        @(negedge clk_pll);
        window("R1 functional edges after test", 400, 50);

        #20;
        drain();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule